// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether the destination address of a received frame falls into the group-address hash set. The address arrives one byte per clock, first byte first. The block runs a CRC-32 over the bytes as they arrive and reverses the bits of the final remainder. The top eight bits of the reversed value become an index into a 256-entry bit table. One cycle after the last byte it reports the index and whether the addressed table entry is set.

The table is held in eight 32-bit registers that a simple write port loads. Entries are numbered from the most significant end of each register. When the first byte of an address is accepted, the block takes a private copy of the table. Writes made while an address is being hashed therefore take effect from the next address on. Only group addresses, those with bit 0 of the first byte set, can report a hit.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset, res_valid and res_hit are low and res_index is zero.
- R2: An address begins with a byte for which addr_valid and addr_sof are both high. It continues with further bytes that have addr_valid high and addr_sof low. Cycles with addr_valid low pause it. res_valid pulses high for exactly the one cycle that follows the clock edge that accepted the sixth byte.
- R3: The remainder starts at all ones and uses polynomial 0x04C11DB7, shifted MSB first. The bits of each byte enter least significant bit first, and bit 0 of the first byte enters first. No final inversion is applied.
- R4: The 32-bit remainder is bit-reversed. res_index is the top 8 bits of the reversed value, so res_index bit k equals remainder bit 7-k.
- R5: Table entry e sits in register e[7:5] at bit position 31-e[4:0]. Entry 0 is bit 31 of register 0, and entry 255 is bit 0 of register 7. res_hit reports the entry that res_index selects.
- R6: res_hit can be high only when bit 0 of the first address byte is 1. Unicast addresses always report a miss, although the index is still reported.
- R7: When tbl_we is high, tbl_data is written to register tbl_sel. A write is used only by addresses whose first byte arrives in a later cycle. A write made in the cycle of the first byte, or during the address, does not change that address's result.
- R8: Bytes with addr_valid high and addr_sof low while no address is open are ignored and produce no result.
- R9: A byte with addr_sof high that arrives part way through an address discards the partial address and starts a new one.
- R10: res_hit is high only together with res_valid, and res_valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | addr_byte carries an address byte this cycle |
| addr_sof | input | 1 | This byte is the first byte of an address |
| addr_byte | input | 8 | Address byte |
| tbl_we | input | 1 | Table register write strobe |
| tbl_sel | input | 3 | Table register number |
| tbl_data | input | 32 | Table register write data |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Selected table entry set and address is a group address |
| res_index | output | 8 | Hash index of the last address evaluated |

## Verification
The bench sets single table entries next to each other, and also entry 0 and entry 255. A design that numbers bits from the least significant end, or that picks the wrong register, would then report hits on the wrong addresses. It writes the table at the first byte and in the middle of an address, where a design without its own copy of the table would report the new contents too early. Stray bytes sent with no open address, and an address restarted part way through, catch a sequencer that makes results it should not make or that keeps a stale remainder. Every result's index is compared with a model of the CRC, so a wrong bit order, seed or reversal shows up as a wrong index even when the table is empty.

// File: rtl/mhf_pkg.sv
// Shared constants and the bytewise CRC step for the multicast hash filter.
// Assumes the remainder is shifted MSB first while each byte enters LSB first.
package mhf_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // Advance the remainder by one byte, least significant data bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] rem_in,
        input logic [7:0]       data
    );
        logic [CRC_W-1:0] rem;
        logic             fb;
        rem = rem_in;
        for (int i = 0; i < 8; i++) begin
            fb  = rem[CRC_W-1] ^ data[i];
            rem = {rem[CRC_W-2:0], 1'b0};
            if (fb) rem = rem ^ CRC_POLY;
        end
        return rem;
    endfunction
endpackage

// File: rtl/mhf_seq.sv
// Byte sequencer and running CRC for one address.
// Accepts bytes from a start-flagged byte onward and counts them. It raises
// fin combinationally on the byte that completes the address, together with
// the final remainder and the group bit. Assumes ADDR_BYTES >= 2.
module mhf_seq #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic                    in_sof,
    input  logic [7:0]              in_byte,
    output logic                    start,
    output logic                    fin,
    output logic [mhf_pkg::CRC_W-1:0] crc_fin,
    output logic                    grp_fin
);
    import mhf_pkg::*;

    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q;
    logic             grp_q;

    logic             accept;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_nxt;

    // Decide whether this byte belongs to an address and compute its effect.
    always_comb begin
        accept   = in_vld && (in_sof || busy_q);
        start    = in_vld && in_sof;
        crc_base = in_sof ? CRC_SEED : crc_q;
        crc_nxt  = crc_step_byte(crc_base, in_byte);
        cnt_nxt  = in_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
        fin      = accept && (cnt_nxt == CNT_W'(ADDR_BYTES));
        crc_fin  = crc_nxt;
        grp_fin  = in_sof ? in_byte[0] : grp_q;
    end

    // Hold the partial remainder, byte count and group bit between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            crc_q  <= CRC_SEED;
            grp_q  <= 1'b0;
        end else if (accept) begin
            busy_q <= !fin;
            cnt_q  <= fin ? '0 : cnt_nxt;
            crc_q  <= crc_nxt;
            if (in_sof) grp_q <= in_byte[0];
        end
    end
endmodule

// File: rtl/mhf_table.sv
// Hash table registers plus a per-address snapshot.
// Live registers take writes at any time. The snapshot copies the live
// registers, excluding a same-cycle write, when an address starts. The
// snapshot is flattened in entry order with MSB-first bit numbering.
module mhf_table #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 32,
    localparam int ENTRIES = NUM_REGS * REG_W,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               take,
    output logic [ENTRIES-1:0] snap_ent
);
    logic [REG_W-1:0] live_q [NUM_REGS];
    logic [REG_W-1:0] snap_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Load one live register from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   live_q[r] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(r)))      live_q[r] <= wr_data;
        end

        // Freeze this register's contents for the address now starting.
        always_ff @(posedge clk) begin
            if (!rst_n)    snap_q[r] <= '0;
            else if (take) snap_q[r] <= live_q[r];
        end

        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            assign snap_ent[r*REG_W + (REG_W-1-b)] = snap_q[r][b];
        end
    end
endmodule

// File: rtl/mhf_lookup.sv
// Index extraction and result register.
// Bit-reverses the final remainder, takes its top bits as the entry number,
// reads the snapshot entry and registers the strobe, hit and index.
module mhf_lookup #(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fin,
    input  logic [mhf_pkg::CRC_W-1:0] crc_fin,
    input  logic                      grp_fin,
    input  logic [ENTRIES-1:0]        snap_ent,
    output logic                      res_valid,
    output logic                      res_hit,
    output logic [IDX_W-1:0]          res_index
);
    import mhf_pkg::*;

    logic [CRC_W-1:0] crc_rev;
    logic [IDX_W-1:0] idx;
    logic             ent_set;

    for (genvar g = 0; g < CRC_W; g++) begin : g_rev
        assign crc_rev[g] = crc_fin[CRC_W-1-g];
    end

    // Select the entry addressed by the top bits of the reversed remainder.
    always_comb begin
        idx     = crc_rev[CRC_W-1 -: IDX_W];
        ent_set = snap_ent[idx];
    end

    // Register the result one cycle after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_index <= '0;
        end else begin
            res_valid <= fin;
            res_hit   <= fin && grp_fin && ent_set;
            if (fin) res_index <= idx;
        end
    end
endmodule

// File: rtl/mc_hash_filter.sv
// Multicast hash address filter top.
// Serial address bytes in, one-cycle hit/miss strobe out. Table writes are
// taken into a snapshot at the first byte of every address.
module mc_hash_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int NUM_REGS   = 8,
    parameter int REG_W      = 32,
    localparam int ENTRIES   = NUM_REGS * REG_W,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int SEL_W     = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_valid,
    input  logic             addr_sof,
    input  logic [7:0]       addr_byte,
    input  logic             tbl_we,
    input  logic [SEL_W-1:0] tbl_sel,
    input  logic [REG_W-1:0] tbl_data,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_index
);
    import mhf_pkg::*;

    logic               start;
    logic               fin;
    logic [CRC_W-1:0]   crc_fin;
    logic               grp_fin;
    logic [ENTRIES-1:0] snap_ent;

    mhf_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .in_vld(addr_valid), .in_sof(addr_sof), .in_byte(addr_byte),
        .start(start), .fin(fin), .crc_fin(crc_fin), .grp_fin(grp_fin)
    );

    mhf_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_sel(tbl_sel), .wr_data(tbl_data),
        .take(start), .snap_ent(snap_ent)
    );

    mhf_lookup #(.ENTRIES(ENTRIES)) u_lkp (
        .clk(clk), .rst_n(rst_n),
        .fin(fin), .crc_fin(crc_fin), .grp_fin(grp_fin), .snap_ent(snap_ent),
        .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index)
    );
endmodule

// File: rtl/mhf_chk.sv
// Port-level property checker for the multicast hash filter.
// Tracks the group bit of the open address and whether any write occurred.
module mhf_chk (
    input logic clk,
    input logic rst_n,
    input logic addr_valid,
    input logic addr_sof,
    input logic [7:0] addr_byte,
    input logic tbl_we,
    input logic res_valid,
    input logic res_hit
);
    logic grp_q;
    logic wrote_q;

    // Remember the group bit of the most recent first byte and any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= 1'b0;
            wrote_q <= 1'b0;
        end else begin
            if (addr_valid && addr_sof) grp_q <= addr_byte[0];
            if (tbl_we) wrote_q <= 1'b1;
        end
    end

    // R10
    hit_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);
    // R10
    no_double_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R2
    valid_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(addr_valid));
    // R6
    unicast_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !grp_q) |-> !res_hit);
    // R7
    empty_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !wrote_q) |-> !res_hit);
endmodule

bind mc_hash_filter mhf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_sof(addr_sof),
    .addr_byte(addr_byte), .tbl_we(tbl_we), .res_valid(res_valid),
    .res_hit(res_hit)
);

// File: tb/mc_hash_filter_tb.sv
module mc_hash_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic        addr_sof = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_sel = '0;
    logic [31:0] tbl_data = '0;
    logic        res_valid;
    logic        res_hit;
    logic [7:0]  res_index;

    int n_chk = 0;
    int n_bad = 0;
    logic        due = 1'b0;
    logic [8:0]  exp_q [$];
    string       tag_q [$];
    logic [31:0] mtab [8];
    logic [31:0] seed = 32'h1234_5678;
    bit          done = 1'b0;

    mc_hash_filter u_dut (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_sof(addr_sof),
        .addr_byte(addr_byte), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_data(tbl_data), .res_valid(res_valid), .res_hit(res_hit),
        .res_index(res_index)
    );

    always #5 clk = ~clk;

    // R3/R4 reference index from the stated CRC rules.
    function automatic logic [7:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        logic [7:0]  ix;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            fb = c[31] ^ a[k];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        for (int k = 0; k < 8; k++) ix[k] = c[7-k];
        return ix;
    endfunction

    // R5 entry lookup in the model table.
    function automatic logic ent(input logic [7:0] e);
        return mtab[e[7:5]][31 - e[4:0]];
    endfunction

    function automatic logic [47:0] next_addr();
        seed = seed * 32'd1103515245 + 32'd12345;
        next_addr[23:0] = seed[31:8];
        seed = seed * 32'd1103515245 + 32'd12345;
        next_addr[47:24] = seed[31:8];
    endfunction

    task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        tbl_we = 1'b1; tbl_sel = s; tbl_data = d;
        step();
        tbl_we = 1'b0;
        mtab[s] = d;
    endtask

    // Driver: push the expected result, then send six bytes, optionally with
    // a table write on byte wr_at and gap idle cycles between bytes.
    task automatic send_addr(input logic [47:0] a, input string tag,
                             input int wr_at, input logic [2:0] s,
                             input logic [31:0] d, input int gap);
        logic [7:0] ix;
        ix = ref_idx(a);
        exp_q.push_back({a[0] & ent(ix), ix});
        tag_q.push_back(tag);
        for (int k = 0; k < 6; k++) begin
            addr_valid = 1'b1; addr_sof = (k == 0); addr_byte = a[8*k +: 8];
            if (k == wr_at) begin tbl_we = 1'b1; tbl_sel = s; tbl_data = d; end
            step();
            addr_valid = 1'b0; addr_sof = 1'b0; tbl_we = 1'b0;
            if (k == wr_at) mtab[s] = d;
            if (k == 5) begin
                due = 1'b1;
                step();
                due = 1'b0;
            end else begin
                for (int g = 0; g < gap; g++) step();
            end
        end
    endtask

    // Monitor: result strobe must match the expected timing and content.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(res_valid === due, "R2 result strobe timing", 32'(res_valid), 32'(due));
            check(!(res_hit && !res_valid), "R10 hit without strobe", 32'(res_hit), 32'd0);
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", 32'(res_index), 32'd0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(res_index === e[7:0], {t, " R4 index"}, 32'(res_index), 32'(e[7:0]));
                    check(res_hit === e[8], {t, " hit"}, 32'(res_hit), 32'(e[8]));
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 150000 && !done) begin @(posedge clk); cyc++; end
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        logic [7:0]  ix;
        for (int r = 0; r < 8; r++) mtab[r] = '0;
        repeat (3) step();
        // R1 reset state
        check(res_valid === 1'b0, "R1 res_valid at reset", 32'(res_valid), 0);
        check(res_hit === 1'b0, "R1 res_hit at reset", 32'(res_hit), 0);
        check(res_index === 8'd0, "R1 res_index at reset", 32'(res_index), 0);
        rst_n = 1'b1;
        step();
        check(res_valid === 1'b0, "R1 res_valid after release", 32'(res_valid), 0);

        // R3 R4 empty table: every address misses, index still reported
        for (int i = 0; i < 8; i++) begin
            a = next_addr(); a[0] = 1'b1;
            send_addr(a, "R3 empty table", -1, 0, 0, i % 3);
        end

        // R6 full table: group hits, unicast misses
        for (int r = 0; r < 8; r++) wr_reg(3'(r), 32'hFFFF_FFFF);
        for (int i = 0; i < 12; i++) begin
            a = next_addr(); a[0] = i[0];
            send_addr(a, "R6 full table group bit", -1, 0, 0, 0);
        end

        // R5 single entry and its neighbour
        for (int r = 0; r < 8; r++) wr_reg(3'(r), 32'h0);
        for (int i = 0; i < 6; i++) begin
            a = next_addr(); a[0] = 1'b1;
            ix = ref_idx(a);
            wr_reg(ix[7:5], 32'h1 << (31 - ix[4:0]));
            send_addr(a, "R5 exact entry bit", -1, 0, 0, 0);
            wr_reg(ix[7:5], 32'h1 << (31 - (ix[4:0] ^ 5'd1)));
            send_addr(a, "R5 neighbour entry bit", -1, 0, 0, 1);
            wr_reg(ix[7:5], 32'h0);
        end

        // R5 entry 0 and entry 255 only, across a sweep
        wr_reg(3'd0, 32'h8000_0000);
        wr_reg(3'd7, 32'h0000_0001);
        for (int i = 0; i < 300; i++) begin
            a = next_addr(); a[0] = 1'b1;
            send_addr(a, "R5 end entries sweep", -1, 0, 0, i % 2);
        end

        // R7 writes during and at the start of an address
        for (int r = 0; r < 8; r++) wr_reg(3'(r), 32'hFFFF_FFFF);
        a = next_addr(); a[0] = 1'b1;
        ix = ref_idx(a);
        send_addr(a, "R7 write mid address", 2, ix[7:5], 32'h0, 0);
        send_addr(a, "R7 write now visible", -1, 0, 0, 0);
        send_addr(a, "R7 write at first byte", 0, ix[7:5], 32'hFFFF_FFFF, 0);
        send_addr(a, "R7 write at first byte now visible", -1, 0, 0, 0);
        send_addr(a, "R7 write at last byte", 5, ix[7:5], 32'h0, 0);

        // R8 stray bytes with no open address
        for (int k = 0; k < 4; k++) begin
            addr_valid = 1'b1; addr_sof = 1'b0; addr_byte = 8'hA5 + 8'(k);
            step();
        end
        addr_valid = 1'b0;
        repeat (3) step();
        check(exp_q.size() == 0, "R8 stray bytes queue", 32'(exp_q.size()), 0);

        // R9 restart part way through
        a = next_addr();
        for (int k = 0; k < 3; k++) begin
            addr_valid = 1'b1; addr_sof = (k == 0); addr_byte = a[8*k +: 8];
            step();
        end
        addr_valid = 1'b0;
        a = next_addr(); a[0] = 1'b1;
        send_addr(a, "R9 restart", -1, 0, 0, 0);

        // R10 back-to-back addresses without idle cycles
        for (int i = 0; i < 6; i++) begin
            a = next_addr(); a[0] = 1'b1;
            send_addr(a, "R10 back to back", -1, 0, 0, 0);
        end

        repeat (4) step();
        check(exp_q.size() == 0, "R2 all results delivered", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule